// File: doc/BRIEF.md
# LIN Slave Autobaud Synchronizer

This block recovers the bit rate of a LIN master on a slave node. When it runs in slave mode and an external detector has flagged a break, the block waits for the falling edge of the start bit of the 0x55 synchronization byte. It then counts sampling-clock cycles until the fourth falling edge after that start edge. The synchronization byte puts that edge exactly eight bit times after the start edge.

The captured count is split in two. The bits above the lowest three form the new integer clock divider. The lowest three bits, which are the count modulo eight, form the new fractional part. The new pair reaches the output register only after the stop bit has been seen high. Until then the previous divider and fraction remain in use.

If the count runs past the counter width, or the stop bit is low, an error flag is raised and the divider and fraction are left untouched. A downstream baud generator takes `div_o` and `frac_o` directly, and it may use `load_o` to restart its prescaler.

Top module: `lin_autobaud`

## Requirements
- R1: After reset `div_o` equals parameter INIT_DIV, `frac_o` equals INIT_FRAC, and `load_o` and `sync_err_o` are 0.
- R2: While `slave_i` or `enable_i` is 0, no measurement runs, and neither `div_o`/`frac_o` nor `load_o` changes, whatever `rxd_i` does.
- R3: A measurement is armed only by a 1 on `brk_det_i` while idle; a synchronization-shaped waveform on `rxd_i` without it produces no load.
- R4: The captured count N is the number of clock cycles between the start-bit falling edge and the fourth following falling edge on `rxd_i`; on success `div_o` = N >> 3 (bits CNT_W-1..3) and `frac_o` = N mod 8 (bits 2..0).
- R5: `div_o` and `frac_o` keep their previous value during the whole field and change only in the cycle where `load_o` is 1.
- R6: `rxd_i` is sampled 1.5 bit times (N/8 + N/16 cycles) after the last falling edge; if it is 0 there, `sync_err_o` becomes 1 and no load happens.
- R7: If N does not fit in CNT_W bits, `sync_err_o` becomes 1 and no load happens.
- R8: `load_o` is a single-cycle pulse; `sync_err_o` stays 1 until the start edge of the next armed measurement, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; the measurement counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Block enable |
| slave_i | input | 1 | 1 when the node is configured as a LIN slave |
| rxd_i | input | 1 | Asynchronous LIN receive line |
| brk_det_i | input | 1 | Break-detected flag from the receiver |
| div_o | output | CNT_W-3 | Integer baud divider |
| frac_o | output | 3 | Fractional baud divider |
| load_o | output | 1 | One-cycle strobe: new divider and fraction valid |
| sync_err_o | output | 1 | Synchronization failed (overflow or low stop bit) |

## Verification
The bench builds the block with CNT_W = 12, INIT_DIV = 37 and INIT_FRAC = 2. The narrow counter makes the overflow boundary reachable at a field length of 4096 cycles. Both sides of it (4095 and 4096) and a well-overflowed field therefore run within a short simulation. Random field lengths between 64 and 2000 cycles, uneven edge spacing and occasional low stop bits cover every fraction value and the error path.

// File: rtl/lin_ab_pkg.sv
// Shared types of the LIN autobaud synchronizer.
// Assumes: nothing beyond a single clock domain for its users.
package lin_ab_pkg;

    // Measurement phases of the synchronizer controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2,
        ST_STOP  = 2'd3
    } ab_state_t;

endpackage

// File: rtl/lin_ab_rxsync.sv
// Receive-line conditioner: brings the asynchronous line into the clock
// domain through a flop chain and flags each high-to-low transition of
// the synchronized value for one cycle.
// Assumes: line idles high (recessive); reset state reflects that.
module lin_ab_rxsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], rx_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Synchronized level and falling-edge pulse.
    always_comb begin
        rx_o   = sync_q[STAGES-1];
        fall_o = prev_q & ~sync_q[STAGES-1];
    end

endmodule

// File: rtl/lin_ab_timer.sv
// Interval counter of the synchronizer: clears on request, counts up on
// request and keeps a sticky flag once it has wrapped past its width.
// Assumes: clear has priority over increment.
module lin_ab_timer #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic [CNT_W:0] nxt;

    // Widened next value so the carry out is visible.
    always_comb nxt = {1'b0, cnt_o} + 1'b1;

    // Counter and sticky wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (clr_i) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (inc_i) begin
            cnt_o <= nxt[CNT_W-1:0];
            ovf_o <= ovf_o | nxt[CNT_W];
        end
    end

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0 && !ovf_o)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o); // R7

endmodule

// File: rtl/lin_ab_fsm.sv
// Synchronizer controller. Arms on a break flag, starts timing at the next
// falling edge, captures the count at the last falling edge of the 0x55
// field, then samples the stop bit 1.5 bit times later and either commits
// the capture or raises the error flag.
// Assumes: the timer clears on tmr_clr_o and counts on tmr_inc_o.
module lin_ab_fsm
    import lin_ab_pkg::*;
#(
    parameter int CNT_W  = 19,
    parameter int FRAC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             brk_i,
    input  logic             rx_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_ovf_i,
    output logic             tmr_clr_o,
    output logic             tmr_inc_o,
    output logic             commit_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             err_o
);

    localparam int SYNC_FALLS = (1 << FRAC_W) / 2;
    localparam int EDGE_W     = $clog2(SYNC_FALLS);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(SYNC_FALLS - 1);

    ab_state_t         state_q, state_d;
    logic [EDGE_W-1:0] edges_q;
    logic [CNT_W:0]    cap_full;
    logic              cap_ovf;
    logic [CNT_W-1:0]  target;
    logic              start, capture, fail;

    // Count including the current cycle, and its overflow.
    always_comb begin
        cap_full = {1'b0, cnt_i} + 1'b1;
        cap_ovf  = cnt_ovf_i | cap_full[CNT_W];
    end

    // Stop-bit sample point: one and a half bit times after the capture.
    always_comb target = (cap_o >> FRAC_W) + (cap_o >> (FRAC_W + 1));

    // Next-state and timer control.
    always_comb begin
        state_d   = state_q;
        tmr_clr_o = 1'b0;
        tmr_inc_o = 1'b0;
        commit_o  = 1'b0;
        start     = 1'b0;
        capture   = 1'b0;
        fail      = 1'b0;
        if (!run_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (brk_i) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (fall_i) begin
                        start     = 1'b1;
                        tmr_clr_o = 1'b1;
                        state_d   = ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    tmr_inc_o = 1'b1;
                    if (fall_i && edges_q == LAST_EDGE) begin
                        tmr_clr_o = 1'b1;
                        capture   = 1'b1;
                        if (cap_ovf) begin
                            fail    = 1'b1;
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    tmr_inc_o = 1'b1;
                    if (cnt_i == target) begin
                        if (rx_i) commit_o = 1'b1;
                        else      fail     = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State, edge tally, captured count and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            edges_q <= '0;
            cap_o   <= '0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start)
                edges_q <= '0;
            else if (state_q == ST_MEAS && fall_i)
                edges_q <= edges_q + 1'b1;
            if (capture) cap_o <= cap_full[CNT_W-1:0];
            if (start)     err_o <= 1'b0;
            else if (fail) err_o <= 1'b1;
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == ST_IDLE)); // R2
    AST_ARM_NEEDS_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !brk_i) |=> (state_q == ST_IDLE)); // R3
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(state_q == ST_ARMED && fall_i && run_i)) |=> err_o); // R8

endmodule

// File: rtl/lin_ab_ratereg.sv
// Baud-rate register: holds the divider and fraction in use, loads both
// from the captured count on commit and flags the load for one cycle.
// Assumes: commit is never asserted on two consecutive cycles.
module lin_ab_ratereg #(
    parameter int CNT_W     = 19,
    parameter int FRAC_W    = 3,
    parameter int INIT_DIV  = 1,
    parameter int INIT_FRAC = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [CNT_W-1:0]        cap_i,
    output logic [CNT_W-FRAC_W-1:0] div_o,
    output logic [FRAC_W-1:0]       frac_o,
    output logic                    load_o
);

    localparam int DIV_W = CNT_W - FRAC_W;

    // Register update: upper bits to divider, lower bits to fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_o  <= DIV_W'(INIT_DIV);
            frac_o <= FRAC_W'(INIT_FRAC);
            load_o <= 1'b0;
        end else begin
            load_o <= commit_i;
            if (commit_i) begin
                div_o  <= cap_i[CNT_W-1:FRAC_W];
                frac_o <= cap_i[FRAC_W-1:0];
            end
        end
    end

    AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o != $past(div_o) || frac_o != $past(frac_o)) |-> load_o); // R5
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o); // R8

endmodule

// File: rtl/lin_autobaud.sv
// LIN slave autobaud synchronizer top: conditions the receive line, times
// the synchronization byte and updates the divider/fraction register.
// Assumes: clk is the receiver sampling clock; brk_det_i comes from a
// break detector in the same clock domain.
module lin_autobaud #(
    parameter  int CNT_W     = 19,
    parameter  int INIT_DIV  = 16,
    parameter  int INIT_FRAC = 0,
    localparam int FRAC_W    = 3,
    localparam int DIV_W     = CNT_W - FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             slave_i,
    input  logic             rxd_i,
    input  logic             brk_det_i,
    output logic [DIV_W-1:0] div_o,
    output logic [2:0]       frac_o,
    output logic             load_o,
    output logic             sync_err_o
);

    logic             run, rx_s, fall;
    logic             tmr_clr, tmr_inc, tmr_ovf, commit;
    logic [CNT_W-1:0] tmr_cnt, cap;

    // Synchronization runs only as an enabled slave.
    always_comb run = enable_i & slave_i;

    lin_ab_rxsync #(.STAGES(2)) u_rxsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rxd_i),
        .rx_o   (rx_s),
        .fall_o (fall)
    );

    lin_ab_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .cnt_o (tmr_cnt),
        .ovf_o (tmr_ovf)
    );

    lin_ab_fsm #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .brk_i     (brk_det_i),
        .rx_i      (rx_s),
        .fall_i    (fall),
        .cnt_i     (tmr_cnt),
        .cnt_ovf_i (tmr_ovf),
        .tmr_clr_o (tmr_clr),
        .tmr_inc_o (tmr_inc),
        .commit_o  (commit),
        .cap_o     (cap),
        .err_o     (sync_err_o)
    );

    lin_ab_ratereg #(
        .CNT_W     (CNT_W),
        .FRAC_W    (FRAC_W),
        .INIT_DIV  (INIT_DIV),
        .INIT_FRAC (INIT_FRAC)
    ) u_ratereg (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .cap_i    (cap),
        .div_o    (div_o),
        .frac_o   (frac_o),
        .load_o   (load_o)
    );

endmodule

// File: tb/test_lin_autobaud.sv
module test_lin_autobaud;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int DIV_W      = CNT_W - 3;
    localparam int INIT_DIV   = 37;
    localparam int INIT_FRAC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, slave = 1'b0, rxd = 1'b1, brk = 1'b0;
    logic [DIV_W-1:0] div;
    logic [2:0] frac;
    logic load, err;

    int checks = 0, fails = 0, cycles = 0;
    int loads = 0, run_len = 0, max_run = 0;
    int exp_div_v = INIT_DIV, exp_frac_v = INIT_FRAC;
    bit exp_err = 1'b0;

    lin_autobaud #(.CNT_W(CNT_W), .INIT_DIV(INIT_DIV), .INIT_FRAC(INIT_FRAC)) i_lin_autobaud (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .slave_i(slave),
        .rxd_i(rxd), .brk_det_i(brk), .div_o(div), .frac_o(frac),
        .load_o(load), .sync_err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int f_div(int n);
        return (n >> 3) & ((1 << DIV_W) - 1);
    endfunction
    function automatic int f_frac(int n);
        return n & 7;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Load pulse counting and pulse-width tracking, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && load) begin
            loads++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=195000", cycles);
            summary();
        end
    end

    task automatic hold(logic v, int c);
        rxd = v;
        repeat (c) @(posedge clk);
        #1;
    endtask

    // Break, delimiter and a 0x55 field of n cycles, then stop bit.
    task automatic frame(int n, bit with_brk, bit stop_ok, string tag);
        int t, l0;
        bit active, ovf;
        t = n / 8;
        l0 = loads;
        active = enable && slave && with_brk;
        ovf = (n >= (1 << CNT_W));
        hold(1'b1, 20);
        hold(1'b0, 13 * t);
        rxd = 1'b1;
        brk = with_brk;
        @(posedge clk); #1;
        brk = 1'b0;
        hold(1'b1, t);
        for (int k = 0; k < 4; k++) begin
            hold(1'b0, (n * (2*k+1)) / 8 - (n * 2*k) / 8);
            hold(1'b1, (n * (2*k+2)) / 8 - (n * (2*k+1)) / 8);
        end
        check({tag, " R5 div held before field end"}, int'(div), exp_div_v);
        check({tag, " R5 no early load"}, loads - l0, 0);
        hold(1'b0, stop_ok ? t : 2 * t);
        hold(1'b1, n / 2 + 20);
        if (active) begin
            if (ovf || !stop_ok) exp_err = 1'b1;
            else begin
                exp_err = 1'b0;
                exp_div_v = f_div(n);
                exp_frac_v = f_frac(n);
            end
        end
        check({tag, " load count"}, loads - l0, (active && !ovf && stop_ok) ? 1 : 0);
        check({tag, " div"}, int'(div), exp_div_v);
        check({tag, " frac"}, int'(frac), exp_frac_v);
        check({tag, " err"}, int'(err), int'(exp_err));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1;
        check("R1 div reset", int'(div), INIT_DIV);
        check("R1 frac reset", int'(frac), INIT_FRAC);
        check("R1 load reset", int'(load), 0);
        check("R1 err reset", int'(err), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        slave = 1'b1;
        frame(365, 1, 1, "R4 n=365");
        frame(64, 1, 1, "R4 n=64");
        frame(4095, 1, 1, "R4 n=4095");
        frame(4096, 1, 1, "R7 n=4096");
        frame(900, 1, 1, "R8 err cleared");
        frame(4500, 1, 1, "R7 n=4500");
        frame(800, 1, 0, "R6 low stop");
        frame(1001, 1, 1, "R8 after R6");
        frame(600, 0, 1, "R3 no break");
        slave = 1'b0;
        frame(600, 1, 1, "R2 master mode");
        slave = 1'b1;
        enable = 1'b0;
        frame(600, 1, 1, "R2 disabled");
        enable = 1'b1;
        for (int i = 0; i < 12; i++) begin
            int n;
            bit ok;
            n = 64 + int'($urandom_range(0, 1936));
            ok = ($urandom_range(0, 3) != 0);
            frame(n, 1, ok, ok ? "R4 random" : "R6 random");
        end
        check("R8 load pulse width", max_run, 1);
        summary();
    end
endmodule